// File: doc/BRIEF.md
# Hibernate State and Pin Controller

This block decides whether the chip runs in its active state or in a low-power hibernate state. A control bit held by the register file requests hibernation. When that bit is cleared, the block leaves hibernation in one of two ways, chosen by a wake-path bit. It can go straight back to active. It can also go through a startup state, where it waits for the external startup sequencer to report completion. A third bit decides whether leaving hibernation also fires a one-cycle internal register-reset strobe.

While the block is hibernating, it takes over three active-low output pins: the system reset, the memory reset and the interrupt line. Each pin has its own mode bit. The mode bit either parks the pin at a fixed level or, for the interrupt pin, lets the pin work normally. In every other state the functional values of the pins pass through unchanged. Software sets the mode bits and the hibernate bit, and the startup sequencer drives the startup-done handshake.

Top module: `hib_ctrl`

## Requirements
- R1: After reset, `state_o` reads ACTIVE (encoding 2'b00), `reg_rst_o` is 0 and all pins pass their functional values.
- R2: In ACTIVE, when `hib_req_i` is 1, `state_o` changes to HIBERNATE (2'b01) on the next clock edge. When it is 0, the state stays ACTIVE.
- R3: In HIBERNATE, when `hib_req_i` is 0 and `wake_via_startup_i` is 0, the state changes to ACTIVE on the next edge. While `hib_req_i` stays 1, the state stays HIBERNATE.
- R4: In HIBERNATE, when `hib_req_i` is 0 and `wake_via_startup_i` is 1, the state changes to STARTUP (2'b10) on the next edge. STARTUP holds until `startup_done_i` is 1 at an edge, and then moves to ACTIVE. `hib_req_i` has no effect in STARTUP. `startup_done_i` has no effect in ACTIVE or HIBERNATE.
- R5: `reg_rst_o` is 1 for exactly one cycle. That cycle is the first one after the state leaves HIBERNATE, and only when `keep_regs_i` was 0 at the leaving edge. At every other time it is 0, including every exit made with `keep_regs_i` at 1.
- R6: In HIBERNATE, `rst_n_o` is 0 when `rst_mode_i` is 0 and 1 when `rst_mode_i` is 1.
- R7: In HIBERNATE, `memrst_n_o` is 0 when `memrst_mode_i` is 0 and 1 when `memrst_mode_i` is 1.
- R8: In HIBERNATE, `irq_n_o` follows `irq_n_func_i` when `irq_mode_i` is 0, and is forced to 1 (no interrupt) when `irq_mode_i` is 1.
- R9: In ACTIVE and STARTUP, the three pin outputs equal their functional inputs, whatever the mode bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hib_req_i | input | 1 | Hibernate request bit (1 = hibernate) |
| wake_via_startup_i | input | 1 | Wake path: 0 = direct to active, 1 = through startup |
| keep_regs_i | input | 1 | 1 suppresses the register reset on wake |
| rst_mode_i | input | 1 | Reset pin level in hibernate (0 low, 1 high) |
| memrst_mode_i | input | 1 | Memory-reset pin level in hibernate (0 low, 1 high) |
| irq_mode_i | input | 1 | Interrupt pin in hibernate (0 normal, 1 forced high) |
| startup_done_i | input | 1 | Startup sequence finished |
| rst_n_func_i | input | 1 | Functional reset pin value |
| memrst_n_func_i | input | 1 | Functional memory-reset pin value |
| irq_n_func_i | input | 1 | Functional interrupt pin value |
| state_o | output | 2 | Current state: 00 active, 01 hibernate, 10 startup |
| reg_rst_o | output | 1 | One-cycle register-reset strobe on wake |
| rst_n_o | output | 1 | Final reset pin value |
| memrst_n_o | output | 1 | Final memory-reset pin value |
| irq_n_o | output | 1 | Final interrupt pin value |

## Verification
The bench drops the hibernate request while the wake-path and keep-registers bits take every combination. A design that misroutes the wake path shows up as a wrong state in the following cycle, and one that ignores the keep bit either pulses the strobe when it should not or never pulses it. Two further cases target mistakes that are easy to make. One asserts startup-done early, while the block is still hibernating, which catches a design that skips the startup wait. The other raises the hibernate request during STARTUP, which catches a design that re-enters hibernation from there. Randomised pin values and mode bits in every state expose an interrupt override that inverts or swallows the functional value, and a pin mux that keys on the wrong state.

// File: rtl/hib_pkg.sv
package hib_pkg;
  localparam int STATE_W = 2;
  localparam int PIN_CNT = 3;
  // pin vector order: 0 reset, 1 memory reset, 2 irq
  localparam int PIN_RST    = 0;
  localparam int PIN_MEMRST = 1;
  localparam int PIN_IRQ    = 2;
  // bit set: mode 0 passes the functional value instead of driving low
  localparam logic [PIN_CNT-1:0] PASS_ON_CLR = 3'b100;

  typedef enum logic [STATE_W-1:0] {
    ST_ACTIVE  = 2'b00,
    ST_HIB     = 2'b01,
    ST_STARTUP = 2'b10
  } hib_state_e;
endpackage

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hib_req_i,
  input  logic       wake_via_startup_i,
  input  logic       keep_regs_i,
  input  logic       startup_done_i,
  output hib_state_e state_o,
  output logic       reg_rst_o
);
  hib_state_e state_q, state_d;
  logic       reg_rst_q, reg_rst_d;

  always_comb begin
    state_d   = state_q;
    reg_rst_d = 1'b0;
    unique case (state_q)
      ST_ACTIVE:  if (hib_req_i) state_d = ST_HIB;
      ST_HIB: begin
        if (!hib_req_i) begin
          state_d   = wake_via_startup_i ? ST_STARTUP : ST_ACTIVE;
          reg_rst_d = !keep_regs_i;
        end
      end
      ST_STARTUP: if (startup_done_i) state_d = ST_ACTIVE;
      default:    state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ACTIVE;
      reg_rst_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      reg_rst_q <= reg_rst_d;
    end
  end

  assign state_o   = state_q;
  assign reg_rst_o = reg_rst_q;

  AST_HIB_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && hib_req_i) |=> state_q == ST_HIB); // R2
  AST_STARTUP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STARTUP && !startup_done_i) |=> state_q == ST_STARTUP); // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_q |=> !reg_rst_q); // R5
  AST_STROBE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rst_q |-> ($past(state_q) == ST_HIB && state_q != ST_HIB && !$past(keep_regs_i))); // R5
  AST_LEGAL_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != 2'b11); // R1
endmodule

// File: rtl/hib_pin_ovr.sv
module hib_pin_ovr #(
  parameter bit PASS_ON_CLR = 1'b0
) (
  input  logic hib_i,
  input  logic mode_i,
  input  logic func_i,
  output logic pin_o
);
  logic hib_val;

  generate
    if (PASS_ON_CLR) begin : g_pass
      assign hib_val = mode_i ? 1'b1 : func_i;
    end else begin : g_fixed
      assign hib_val = mode_i;
    end
  endgenerate

  assign pin_o = hib_i ? hib_val : func_i;
endmodule

// File: rtl/hib_ctrl.sv
module hib_ctrl
  import hib_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hib_req_i,
  input  logic               wake_via_startup_i,
  input  logic               keep_regs_i,
  input  logic               rst_mode_i,
  input  logic               memrst_mode_i,
  input  logic               irq_mode_i,
  input  logic               startup_done_i,
  input  logic               rst_n_func_i,
  input  logic               memrst_n_func_i,
  input  logic               irq_n_func_i,
  output logic [STATE_W-1:0] state_o,
  output logic               reg_rst_o,
  output logic               rst_n_o,
  output logic               memrst_n_o,
  output logic               irq_n_o
);
  hib_state_e         state;
  logic               in_hib;
  logic [PIN_CNT-1:0] mode_vec, func_vec, pin_vec;

  hib_fsm u_fsm (
    .clk_i              (clk_i),
    .rst_ni             (rst_ni),
    .hib_req_i          (hib_req_i),
    .wake_via_startup_i (wake_via_startup_i),
    .keep_regs_i        (keep_regs_i),
    .startup_done_i     (startup_done_i),
    .state_o            (state),
    .reg_rst_o          (reg_rst_o)
  );

  assign in_hib   = (state == ST_HIB);
  assign mode_vec = {irq_mode_i, memrst_mode_i, rst_mode_i};
  assign func_vec = {irq_n_func_i, memrst_n_func_i, rst_n_func_i};

  for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
    hib_pin_ovr #(.PASS_ON_CLR(PASS_ON_CLR[i])) u_ovr (
      .hib_i  (in_hib),
      .mode_i (mode_vec[i]),
      .func_i (func_vec[i]),
      .pin_o  (pin_vec[i])
    );
  end

  assign state_o    = state;
  assign rst_n_o    = pin_vec[PIN_RST];
  assign memrst_n_o = pin_vec[PIN_MEMRST];
  assign irq_n_o    = pin_vec[PIN_IRQ];

  AST_PINS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != ST_HIB) |-> (rst_n_o == rst_n_func_i && memrst_n_o == memrst_n_func_i
                             && irq_n_o == irq_n_func_i)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HIB && irq_mode_i) |-> irq_n_o); // R8
  AST_RST_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HIB) |-> (rst_n_o == rst_mode_i)); // R6
  AST_MEMRST_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_HIB) |-> (memrst_n_o == memrst_mode_i)); // R7
endmodule

// File: tb/hib_ctrl_test.sv
`timescale 1ns/1ps
module hib_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic hib_req = 0, via_su = 0, keep = 0, rmode = 0, mmode = 0, imode = 0, su_done = 0;
  logic rfunc = 1, mfunc = 1, ifunc = 1;
  logic [1:0] state;
  logic rr, rpin, mpin, ipin;

  hib_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .hib_req_i(hib_req), .wake_via_startup_i(via_su),
    .keep_regs_i(keep), .rst_mode_i(rmode), .memrst_mode_i(mmode), .irq_mode_i(imode),
    .startup_done_i(su_done), .rst_n_func_i(rfunc), .memrst_n_func_i(mfunc),
    .irq_n_func_i(ifunc), .state_o(state), .reg_rst_o(rr), .rst_n_o(rpin),
    .memrst_n_o(mpin), .irq_n_o(ipin)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_state = 0;  // 0 active, 1 hibernate, 2 startup
  bit m_rr = 0;

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_rr <= 0;
    end else begin
      m_rr <= 0;
      if (m_state == 0 && hib_req) m_state <= 1;
      else if (m_state == 1 && !hib_req) begin
        m_state <= via_su ? 2 : 0;
        m_rr <= !keep;
      end else if (m_state == 2 && su_done) m_state <= 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit hib;
    hib = (m_state == 1);
    chk("R2 R3 R4 state", state, m_state);
    chk("R5 reg_rst strobe", rr, m_rr);
    chk(hib ? "R6 rst pin" : "R9 rst pin", rpin, hib ? rmode : rfunc);
    chk(hib ? "R7 memrst pin" : "R9 memrst pin", mpin, hib ? mmode : mfunc);
    chk(hib ? "R8 irq pin" : "R9 irq pin", ipin, hib ? (imode ? 1 : ifunc) : ifunc);
  endtask

  // every clock: sample at negedge, then move inputs
  task automatic cyc();
    @(negedge clk);
    compare_all();
    rfunc = $urandom; mfunc = $urandom; ifunc = $urandom;
  endtask

  task automatic wake(input bit su, input bit kp);
    hib_req = 1; via_su = su; keep = kp;
    cyc(); cyc();
    chk("R2 entered hibernate", state, 1);
    hib_req = 0;
    cyc();
    chk("R5 strobe on exit", rr, !kp);
    chk(su ? "R4 startup path" : "R3 direct path", state, su ? 2 : 0);
    cyc();
    chk("R5 strobe one cycle", rr, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset state", state, 0);
    chk("R1 reset strobe", rr, 0);
    chk("R1 reset pin", rpin, rfunc);
    rst_n = 1;
    cyc();
    // directed wakes in all combinations
    for (int k = 0; k < 4; k++) begin
      rmode = k[0]; mmode = k[1]; imode = k[0] ^ k[1];
      wake(k[0], k[1]);
      if (k[0]) begin
        // startup holds while done low, request ignored
        hib_req = 1; su_done = 0;
        cyc(); cyc();
        chk("R4 startup holds, request ignored", state, 2);
        hib_req = 0; su_done = 1;
        cyc();
        chk("R4 startup done to active", state, 0);
        su_done = 0;
      end
      cyc();
    end
    // early done while hibernating must not skip startup
    hib_req = 1; via_su = 1; keep = 1;
    cyc(); cyc();
    su_done = 1; cyc(); cyc();
    chk("R4 done ignored in hibernate", state, 1);
    hib_req = 0; su_done = 0; cyc();
    chk("R4 exit into startup", state, 2);
    su_done = 1; cyc(); su_done = 0; cyc();
    // irq normal mode in hibernate with both pin levels
    hib_req = 1; imode = 0; cyc(); cyc();
    ifunc = 0; @(negedge clk); chk("R8 irq pass low", ipin, 0); compare_all();
    ifunc = 1; #1; chk("R8 irq pass high", ipin, 1);
    hib_req = 0; via_su = 0; cyc(); cyc();
    // random soak
    for (int n = 0; n < 3000; n++) begin
      hib_req = ($urandom % 4) != 0 ? hib_req : ~hib_req;
      via_su = $urandom; keep = $urandom; su_done = ($urandom % 3) == 0;
      rmode = $urandom; mmode = $urandom; imode = $urandom;
      cyc();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule